// File: doc/BRIEF.md
# Extended-Precision Add Special-Operand Resolver

This block sits in front of the significand adder of an 80-bit extended-format floating-point add unit. It receives a destination and a source operand, the current rounding mode and a marker telling it that the source came from an integer conversion. Each operand is classified into one of seven classes. Every operand pair whose sum can be settled without arithmetic gets its final result and its exception flags here. Such pairs involve a NaN, an infinity, a zero or an encoding the unit does not accept.

Only pairs of two non-zero finite operands (normal or denormal) go to the external significand adder. For those pairs the block raises an add request and forwards both operands unchanged. It also supplies the sign that the adder must give an exactly cancelling sum. Overflow, underflow and inexact detection for such sums belong to the external adder.

All outputs are registered and appear one clock after the cycle in which `in_valid` is high.

Top module: `fpx_add_special`

## Requirements
- R1: Operand format is sign in bit 79, a 15-bit exponent in bits 78:64 and a 64-bit significand in bits 63:0 with an explicit integer bit at bit 63. Each operand is classified as follows, with the class code in brackets:
  - zero [0]: exponent 0 and significand 0.
  - denormal [1]: exponent 0 and a non-zero significand.
  - normal [2]: exponent between 1 and 0x7FFE with the integer bit set.
  - infinity [3]: exponent 0x7FFF and significand 0x8000000000000000.
  - quiet NaN [4]: exponent 0x7FFF with bits 63:62 equal to 11.
  - signalling NaN [5]: exponent 0x7FFF, bits 63:62 equal to 10 and bits 61:0 non-zero.
  - unsupported [6]: any non-zero exponent with the integer bit clear.
- R2: Outputs appear one cycle after an `in_valid` cycle, with `out_valid` high. When both operands are denormal or normal, `add_request` is high, `bypass_valid` is low and `result` is zero. In every other valid case `bypass_valid` is high and `add_request` is low. `fwd_dst` and `fwd_src` always carry the input operands unchanged. In a cycle after `in_valid` is low, `out_valid`, `bypass_valid` and `add_request` are all low.
- R3: The rounding mode codes are 00 to nearest, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. Two zeros of opposite sign give +0, except under code 01, where they give -0. `zero_sign` is 1 exactly when the mode was 01, and the external adder uses it as the sign of an exactly cancelling sum.
- R4: When `src_is_int` is high and the source is a zero, the source is treated as +0 whatever its sign bit.
- R5: Two infinities of the same sign return that infinity. An infinity added to a zero, denormal or normal operand returns the infinity.
- R6: Two infinities of opposite sign raise `flag_invalid` and return the default NaN. The default NaN has sign 1, exponent 0x7FFF and significand 0xC000000000000000.
- R7: A zero added to a denormal or normal operand returns that operand bit for bit. Two zeros of the same sign return that zero.
- R8: If either operand is a NaN, the result is a NaN quieted by setting bit 62. With one NaN, that NaN is returned. With two NaNs, the one with the larger 64-bit significand is returned, and the destination wins a tie.
- R9: A signalling NaN or an unsupported operand raises `flag_invalid`. With an unsupported operand and no NaN, the result is the default NaN.
- R10: `flag_denormal` is high when at least one operand is denormal and neither operand is a NaN or unsupported.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| dst_op | input | 80 | Destination operand |
| src_op | input | 80 | Source operand |
| rnd_mode | input | 2 | Rounding mode code |
| src_is_int | input | 1 | Source was converted from an integer |
| out_valid | output | 1 | Outputs below belong to an accepted pair |
| bypass_valid | output | 1 | `result` and flags are final |
| add_request | output | 1 | Pair must go through the significand adder |
| result | output | 80 | Final result for bypassed pairs |
| fwd_dst | output | 80 | Destination operand forwarded to the adder |
| fwd_src | output | 80 | Source operand forwarded to the adder |
| zero_sign | output | 1 | Sign for an exactly cancelling sum |
| flag_invalid | output | 1 | Invalid-operand exception |
| flag_denormal | output | 1 | Denormal-operand exception |
| dst_class | output | 3 | Class code of the destination |
| src_class | output | 3 | Class code of the source |

## Verification
The bench targets opposite-signed zero pairs under all four rounding modes. A resolver that ignores the mode would give +0 under round-down. It also targets an integer-sourced -0 paired with -0. A block that kept the source sign would give -0 where +0 is due.

Two-NaN pairs with unequal and with equal significands are included. A wrong comparator or tie rule would return the other NaN, and a missing quiet step would leave bit 62 clear. Unsupported encodings at the largest exponent and at mid-range exponents are also driven. A classifier that called them infinities or normals would either miss `flag_invalid` or send them to the adder.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    parameter int EXP_W = 15;
    parameter int MAN_W = 64;

    localparam int TOT_W    = 1 + EXP_W + MAN_W;
    localparam int QBIT     = MAN_W - 2;
    localparam int CLS_W    = 3;
    localparam int N_OPS    = 2;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } xfp_t;

    typedef enum logic [CLS_W-1:0] {
        CL_ZERO   = 3'd0,
        CL_DENORM = 3'd1,
        CL_NORMAL = 3'd2,
        CL_INF    = 3'd3,
        CL_QNAN   = 3'd4,
        CL_SNAN   = 3'd5,
        CL_UNSUP  = 3'd6
    } xcls_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_DOWN    = 2'd1,
        RM_UP      = 2'd2,
        RM_TRUNC   = 2'd3
    } rmode_e;

    typedef struct packed {
        logic bypass;
        logic add_req;
        xfp_t res;
        logic inv;
        logic den;
    } resolve_t;

    function automatic logic cls_is_nan(input xcls_e c);
        return (c == CL_QNAN) || (c == CL_SNAN);
    endfunction

    function automatic logic cls_is_finite_nz(input xcls_e c);
        return (c == CL_DENORM) || (c == CL_NORMAL);
    endfunction

    function automatic xfp_t quieten(input xfp_t v);
        xfp_t q;
        q = v;
        q.man[QBIT] = 1'b1;
        return q;
    endfunction

    function automatic xfp_t default_nan();
        xfp_t d;
        d.sign = 1'b1;
        d.exp  = '1;
        d.man  = '0;
        d.man[MAN_W-1] = 1'b1;
        d.man[QBIT]    = 1'b1;
        return d;
    endfunction

    function automatic xfp_t signed_zero(input logic s);
        xfp_t z;
        z = '0;
        z.sign = s;
        return z;
    endfunction

endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
    import fpx_pkg::*;
(
    input  xfp_t  op_i,
    input  logic  int_src_i,
    output xcls_e cls_o,
    output xfp_t  eff_o
);

    logic exp_ones;
    logic exp_zero;
    logic jbit;
    logic qbit;
    logic frac_lo_nz;
    logic man_nz;

    always_comb begin
        exp_ones   = &op_i.exp;
        exp_zero   = ~|op_i.exp;
        jbit       = op_i.man[MAN_W-1];
        qbit       = op_i.man[QBIT];
        frac_lo_nz = |op_i.man[QBIT-1:0];
        man_nz     = |op_i.man;

        if (exp_zero) begin
            cls_o = man_nz ? CL_DENORM : CL_ZERO;
        end else if (!jbit) begin
            cls_o = CL_UNSUP;
        end else if (exp_ones) begin
            if (qbit)            cls_o = CL_QNAN;
            else if (frac_lo_nz) cls_o = CL_SNAN;
            else                 cls_o = CL_INF;
        end else begin
            cls_o = CL_NORMAL;
        end

        eff_o = op_i;
        if (int_src_i && (cls_o == CL_ZERO)) begin
            eff_o.sign = 1'b0;
        end
    end

endmodule

// File: rtl/fpx_nan_pick.sv
module fpx_nan_pick
    import fpx_pkg::*;
(
    input  xfp_t  a_i,
    input  xfp_t  b_i,
    input  xcls_e cls_a_i,
    input  xcls_e cls_b_i,
    output xfp_t  nan_o
);

    logic a_nan;
    logic b_nan;
    logic b_larger;
    xfp_t chosen;

    always_comb begin
        a_nan    = cls_is_nan(cls_a_i);
        b_nan    = cls_is_nan(cls_b_i);
        b_larger = (b_i.man > a_i.man);

        if (a_nan && b_nan) begin
            chosen = b_larger ? b_i : a_i;
        end else if (b_nan) begin
            chosen = b_i;
        end else begin
            chosen = a_i;
        end
        nan_o = quieten(chosen);
    end

endmodule

// File: rtl/fpx_special_resolve.sv
module fpx_special_resolve
    import fpx_pkg::*;
(
    input  xfp_t     dst_i,
    input  xfp_t     src_i,
    input  xcls_e    cls_d_i,
    input  xcls_e    cls_s_i,
    input  rmode_e   rm_i,
    input  xfp_t     nan_i,
    output resolve_t out_o
);

    logic any_nan;
    logic any_snan;
    logic any_unsup;
    logic any_den;
    logic inf_clash;

    always_comb begin
        any_nan   = cls_is_nan(cls_d_i) || cls_is_nan(cls_s_i);
        any_snan  = (cls_d_i == CL_SNAN) || (cls_s_i == CL_SNAN);
        any_unsup = (cls_d_i == CL_UNSUP) || (cls_s_i == CL_UNSUP);
        any_den   = (cls_d_i == CL_DENORM) || (cls_s_i == CL_DENORM);
        inf_clash = (cls_d_i == CL_INF) && (cls_s_i == CL_INF) &&
                    (dst_i.sign != src_i.sign);

        out_o        = '0;
        out_o.bypass = 1'b1;
        out_o.inv    = any_snan || any_unsup || inf_clash;
        out_o.den    = any_den && !any_nan && !any_unsup;

        if (any_nan) begin
            out_o.res = nan_i;
        end else if (any_unsup || inf_clash) begin
            out_o.res = default_nan();
        end else if (cls_d_i == CL_INF) begin
            out_o.res = dst_i;
        end else if (cls_s_i == CL_INF) begin
            out_o.res = src_i;
        end else if ((cls_d_i == CL_ZERO) && (cls_s_i == CL_ZERO)) begin
            if (dst_i.sign == src_i.sign) out_o.res = dst_i;
            else                          out_o.res = signed_zero(rm_i == RM_DOWN);
        end else if (cls_d_i == CL_ZERO) begin
            out_o.res = src_i;
        end else if (cls_s_i == CL_ZERO) begin
            out_o.res = dst_i;
        end else begin
            out_o.bypass  = 1'b0;
            out_o.add_req = cls_is_finite_nz(cls_d_i) && cls_is_finite_nz(cls_s_i);
        end
    end

endmodule

// File: rtl/fpx_add_special.sv
module fpx_add_special
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [TOT_W-1:0] dst_op,
    input  logic [TOT_W-1:0] src_op,
    input  logic [1:0]       rnd_mode,
    input  logic             src_is_int,
    output logic             out_valid,
    output logic             bypass_valid,
    output logic             add_request,
    output logic [TOT_W-1:0] result,
    output logic [TOT_W-1:0] fwd_dst,
    output logic [TOT_W-1:0] fwd_src,
    output logic             zero_sign,
    output logic             flag_invalid,
    output logic             flag_denormal,
    output logic [CLS_W-1:0] dst_class,
    output logic [CLS_W-1:0] src_class
);

    xfp_t     raw_op [N_OPS];
    xfp_t     eff_op [N_OPS];
    xcls_e    cls    [N_OPS];
    xfp_t     nan_sel;
    resolve_t rslv;
    rmode_e   rm;

    assign raw_op[0] = xfp_t'(dst_op);
    assign raw_op[1] = xfp_t'(src_op);
    assign rm        = rmode_e'(rnd_mode);

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fpx_classify u_cls (
            .op_i      (raw_op[g]),
            .int_src_i ((g == 1) ? src_is_int : 1'b0),
            .cls_o     (cls[g]),
            .eff_o     (eff_op[g])
        );
    end

    fpx_nan_pick u_nan (
        .a_i     (eff_op[0]),
        .b_i     (eff_op[1]),
        .cls_a_i (cls[0]),
        .cls_b_i (cls[1]),
        .nan_o   (nan_sel)
    );

    fpx_special_resolve u_rslv (
        .dst_i   (eff_op[0]),
        .src_i   (eff_op[1]),
        .cls_d_i (cls[0]),
        .cls_s_i (cls[1]),
        .rm_i    (rm),
        .nan_i   (nan_sel),
        .out_o   (rslv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            bypass_valid  <= 1'b0;
            add_request   <= 1'b0;
            result        <= '0;
            fwd_dst       <= '0;
            fwd_src       <= '0;
            zero_sign     <= 1'b0;
            flag_invalid  <= 1'b0;
            flag_denormal <= 1'b0;
            dst_class     <= '0;
            src_class     <= '0;
        end else begin
            out_valid     <= in_valid;
            bypass_valid  <= in_valid && rslv.bypass;
            add_request   <= in_valid && rslv.add_req;
            result        <= rslv.res;
            fwd_dst       <= dst_op;
            fwd_src       <= src_op;
            zero_sign     <= (rm == RM_DOWN);
            flag_invalid  <= in_valid && rslv.inv;
            flag_denormal <= in_valid && rslv.den;
            dst_class     <= cls[0];
            src_class     <= cls[1];
        end
    end

endmodule

// File: rtl/fpx_add_special_chk.sv
module fpx_add_special_chk
    import fpx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic             bypass_valid,
    input logic             add_request,
    input logic [TOT_W-1:0] result,
    input logic [TOT_W-1:0] fwd_dst,
    input logic [TOT_W-1:0] fwd_src,
    input logic             flag_invalid,
    input logic             flag_denormal,
    input logic [CLS_W-1:0] dst_class,
    input logic [CLS_W-1:0] src_class
);

    logic d_fin;
    logic s_fin;
    logic inf_pair_clash;
    logic res_is_qnan;

    assign d_fin = (dst_class == 3'd1) || (dst_class == 3'd2);
    assign s_fin = (src_class == 3'd1) || (src_class == 3'd2);
    assign inf_pair_clash = (dst_class == 3'd3) && (src_class == 3'd3) &&
                            (fwd_dst[TOT_W-1] != fwd_src[TOT_W-1]);
    assign res_is_qnan = (&result[TOT_W-2:MAN_W]) && result[MAN_W-1] && result[QBIT];

    assert_path_excl_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (bypass_valid != add_request));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!bypass_valid && !add_request));

    assert_addreq_finite_R2: assert property (@(posedge clk) disable iff (rst)
        add_request |-> (d_fin && s_fin));

    assert_inv_gives_qnan_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_invalid) |-> res_is_qnan);

    assert_inf_clash_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && inf_pair_clash) |-> (flag_invalid && bypass_valid));

    assert_den_source_R10: assert property (@(posedge clk) disable iff (rst)
        flag_denormal |-> ((dst_class == 3'd1) || (src_class == 3'd1)));

endmodule

bind fpx_add_special fpx_add_special_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .out_valid     (out_valid),
    .bypass_valid  (bypass_valid),
    .add_request   (add_request),
    .result        (result),
    .fwd_dst       (fwd_dst),
    .fwd_src       (fwd_src),
    .flag_invalid  (flag_invalid),
    .flag_denormal (flag_denormal),
    .dst_class     (dst_class),
    .src_class     (src_class)
);

// File: tb/sim_fpx_add_special.sv
module sim_fpx_add_special;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [79:0] dst_op;
    logic [79:0] src_op;
    logic [1:0]  rnd_mode;
    logic        src_is_int;
    logic        out_valid;
    logic        bypass_valid;
    logic        add_request;
    logic [79:0] result;
    logic [79:0] fwd_dst;
    logic [79:0] fwd_src;
    logic        zero_sign;
    logic        flag_invalid;
    logic        flag_denormal;
    logic [2:0]  dst_class;
    logic [2:0]  src_class;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    localparam logic [79:0] DNAN = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};

    always #5 clk = ~clk;

    fpx_add_special u0 (.*);

    function automatic logic [2:0] ref_cls(input logic [79:0] v);
        logic [14:0] e;
        logic [63:0] m;
        e = v[78:64];
        m = v[63:0];
        if (e == 15'd0)           return (m == 64'd0) ? 3'd0 : 3'd1;
        if (!m[63])               return 3'd6;
        if (e != 15'h7FFF)        return 3'd2;
        if (m[62])                return 3'd4;
        if (m[61:0] != 62'd0)     return 3'd5;
        return 3'd3;
    endfunction

    function automatic logic [79:0] gen_op(input int c);
        logic [79:0] v;
        v[79] = 1'($urandom);
        case (c)
            0: v[78:0] = '0;
            1: begin v[78:64] = '0; v[63:0] = {$urandom, $urandom}; if (v[63:0] == 0) v[0] = 1'b1; end
            2: begin v[78:64] = 15'($urandom_range(1, 32766)); v[63:0] = {1'b1, 31'($urandom), $urandom}; end
            3: begin v[78:64] = 15'h7FFF; v[63:0] = 64'h8000_0000_0000_0000; end
            4: begin v[78:64] = 15'h7FFF; v[63:0] = {2'b11, 30'($urandom), $urandom}; end
            5: begin v[78:64] = 15'h7FFF; v[63:0] = {2'b10, 30'($urandom), $urandom}; if (v[61:0] == 0) v[3] = 1'b1; end
            default: begin
                v[78:64] = ($urandom_range(0, 1) == 0) ? 15'h7FFF : 15'($urandom_range(1, 32766));
                v[63:0]  = {1'b0, 31'($urandom), $urandom};
            end
        endcase
        return v;
    endfunction

    task automatic expect_for(input logic [79:0] d, input logic [79:0] s, input logic [1:0] rm,
                              input logic isint, output logic eb, output logic ea,
                              output logic [79:0] er, output logic ei, output logic ed,
                              output string tag);
        logic [2:0] cd;
        logic [2:0] cs;
        logic dn;
        logic sn;
        logic [79:0] ss;
        cd = ref_cls(d);
        cs = ref_cls(s);
        ss = s;
        if (isint && cs == 3'd0) ss[79] = 1'b0;
        dn = (cd == 3'd4) || (cd == 3'd5);
        sn = (cs == 3'd4) || (cs == 3'd5);
        eb = 1'b1; ea = 1'b0; er = '0;
        ei = (cd == 3'd5) || (cs == 3'd5) || (cd == 3'd6) || (cs == 3'd6) ||
             (cd == 3'd3 && cs == 3'd3 && d[79] != s[79]);
        ed = (cd == 3'd1 || cs == 3'd1) && !dn && !sn && cd != 3'd6 && cs != 3'd6;
        if (dn || sn) begin
            tag = "R8";
            if (dn && sn) er = (s[63:0] > d[63:0]) ? s : d;
            else          er = dn ? d : s;
            er[62] = 1'b1;
        end else if (cd == 3'd6 || cs == 3'd6) begin
            tag = "R9"; er = DNAN;
        end else if (cd == 3'd3 && cs == 3'd3 && d[79] != s[79]) begin
            tag = "R6"; er = DNAN;
        end else if (cd == 3'd3 || cs == 3'd3) begin
            tag = "R5"; er = (cd == 3'd3) ? d : s;
        end else if (cd == 3'd0 && cs == 3'd0) begin
            tag = isint ? "R4" : "R3";
            if (d[79] == ss[79]) er = d;
            else                 er = {(rm == 2'b01), 79'd0};
        end else if (cd == 3'd0 || cs == 3'd0) begin
            tag = "R7"; er = (cd == 3'd0) ? s : d;
        end else begin
            tag = "R2"; eb = 1'b0; ea = 1'b1;
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic apply(input logic [79:0] d, input logic [79:0] s, input logic [1:0] rm, input logic isint);
        logic eb;
        logic ea;
        logic [79:0] er;
        logic ei;
        logic ed;
        string tag;
        @(negedge clk);
        dst_op = d; src_op = s; rnd_mode = rm; src_is_int = isint; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        expect_for(d, s, rm, isint, eb, ea, er, ei, ed, tag);
        check(dst_class == ref_cls(d) && src_class == ref_cls(s), "R1 class",
              {74'd0, dst_class, src_class}, {74'd0, ref_cls(d), ref_cls(s)});
        check(out_valid && bypass_valid == eb && add_request == ea, {tag, " path R2"},
              {77'd0, out_valid, bypass_valid, add_request}, {77'd0, 1'b1, eb, ea});
        check(result == er, {tag, " result"}, result, er);
        check(flag_invalid == ei, {tag, " invalid R9"}, {79'd0, flag_invalid}, {79'd0, ei});
        check(flag_denormal == ed, "R10 denormal", {79'd0, flag_denormal}, {79'd0, ed});
        check(fwd_dst == d && fwd_src == s, "R2 forward", fwd_src, s);
        check(zero_sign == (rm == 2'b01), "R3 zero_sign", {79'd0, zero_sign}, {79'd0, rm == 2'b01});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [79:0] pz;
        logic [79:0] nz;
        logic [79:0] pinf;
        logic [79:0] ninf;
        logic [79:0] one;
        logic [79:0] den;
        int seed;
        seed = 32'h1F2E3D4C;
        void'($urandom(seed));
        pz   = 80'd0;
        nz   = {1'b1, 79'd0};
        pinf = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
        ninf = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};
        one  = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
        den  = {1'b1, 15'h0000, 64'h0000_0000_0000_0123};
        rst = 1'b1; in_valid = 1'b0; dst_op = '0; src_op = '0; rnd_mode = '0; src_is_int = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(!out_valid && !bypass_valid && !add_request && result == 0 && !flag_invalid &&
              !flag_denormal && fwd_dst == 0 && fwd_src == 0 && !zero_sign,
              "R11 reset", result, 80'd0);
        rst = 1'b0;
        @(negedge clk);
        // R2: idle cycle keeps path outputs low
        check(!out_valid && !bypass_valid && !add_request, "R2 idle",
              {77'd0, out_valid, bypass_valid, add_request}, 80'd0);
        // R3: opposite zeros under every mode
        for (int m = 0; m < 4; m++) apply(pz, nz, 2'(m), 1'b0);
        // R4: integer -0 source forced to +0
        apply(nz, nz, 2'b10, 1'b1);
        apply(nz, nz, 2'b10, 1'b0);
        // R5 / R6: infinities
        apply(pinf, ninf, 2'b00, 1'b0);
        apply(ninf, ninf, 2'b00, 1'b0);
        apply(one, ninf, 2'b00, 1'b0);
        // R7: zero with finite
        apply(one, nz, 2'b01, 1'b0);
        apply(pz, den, 2'b00, 1'b0);
        // R8: two NaNs, larger significand and tie
        apply({1'b0, 15'h7FFF, 64'hC000_0000_0000_0001}, {1'b1, 15'h7FFF, 64'hA000_0000_0000_0000}, 2'b00, 1'b0);
        apply({1'b0, 15'h7FFF, 64'h9000_0000_0000_0000}, {1'b1, 15'h7FFF, 64'h9000_0000_0000_0000}, 2'b00, 1'b0);
        // R9: unsupported encodings
        apply({1'b0, 15'h7FFF, 64'h0}, one, 2'b00, 1'b0);
        apply(one, {1'b0, 15'h1234, 64'h4000_0000_0000_0000}, 2'b00, 1'b0);
        // R10 / R2: denormal with normal goes to adder
        apply(den, one, 2'b01, 1'b0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            apply(gen_op($urandom_range(0, 6)), gen_op($urandom_range(0, 6)),
                  2'($urandom), 1'($urandom));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule